// File: doc/BRIEF.md
# Sampling Strobe Timing Generator

This block produces the two sampling strobes of an image-sensor analog front end from the main clock and a pixel-rate timing pulse. The data strobe marks the instant the pixel's signal level is held, and the reference strobe marks the instant the feed-through level is held. Both strobes are placed at clock offsets, set by register fields, from a reference edge. The reference edge is the last main-clock rising edge that samples the timing pulse high. The block also drives the clamp switch control and flags timing pulses that are too long.

The timing pulse is sampled on every rising clock edge. The first edge that samples it low after a high run is the pixel start. In clock-synchronous mode the data strobe falls on the pixel start. Its rising edge is placed ahead of that point using the pixel period measured from the last two pixel starts. Width, position, mode and double-sampling enable are captured on each pixel start once the period is known, so a register write made in the middle of a pixel cannot cut a strobe short. Only the single-edge clock mode is covered.

Top module: `pixel_sample_strobe_gen`

## Requirements
- R1: While reset is asserted, and right after it is released with the timing pulse low, every output is low.
- R2: In synchronous mode the data strobe falls on the pixel start, which is the first edge sampling the timing pulse low after 1 to 3 high samples. `data_fall_o` is high for exactly the one cycle after that edge.
- R3: With a steady pixel period that is longer than the width, the data strobe is high for `data_width_sel + 1` cycles (codes 0..3 give 1..4) just before its fall.
- R4: The reference strobe is high for exactly one cycle and falls `ref_pos_sel + 2` edges after the pixel start (codes 0..3 give 2..5). `ref_fall_o` is high for the one cycle after that falling edge.
- R5: `clamp_close_o` is high exactly when the reference strobe is high.
- R6: With `dbl_samp_en` low, the reference strobe, its fall pulse and the clamp control stay low.
- R7: With `sync_mode` low (direct mode), the data strobe equals the timing pulse delayed by one edge, and `data_fall_o` pulses for one cycle after each of its falls.
- R8: `pulse_err_o` rises on the fourth consecutive edge sampling the timing pulse high and clears on the first edge sampling it low. One to three high samples never raise it.
- R9: Once the period is known, the configuration inputs are captured only at a pixel start. A width change made after a pixel start takes effect for the strobe that ends at the second pixel start after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_timing_i | input | 1 | Pixel-rate timing pulse |
| sync_mode | input | 1 | 1: clock-synchronous data strobe, 0: direct pass-through |
| dbl_samp_en | input | 1 | Enables the reference strobe and clamp (correlated double sampling) |
| data_width_sel | input | 2 | Data strobe high time code |
| ref_pos_sel | input | 2 | Reference strobe fall position code |
| data_strobe_o | output | 1 | Data-level sampling strobe |
| data_fall_o | output | 1 | One-cycle marker after a data strobe fall |
| ref_strobe_o | output | 1 | Feed-through sampling strobe |
| ref_fall_o | output | 1 | One-cycle marker after a reference strobe fall |
| clamp_close_o | output | 1 | Clamp switch closed when high |
| pulse_err_o | output | 1 | Timing pulse held high for four or more edges |

## Verification
The hardest case to reach is a width write that lands between a pixel start and the next rising edge of the data strobe. The old value must then still set the coming pulse, and the new value must set only the one after it. The stimulus drives a steady 10-cycle pixel rhythm, writes the width on the third edge of one pixel, and checks the next two strobes for their separate widths. Scenarios also vary the number of high samples from one to four, which shifts the reference edge and exercises the error flag.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
   localparam int WSEL_W = 2;
   localparam int PSEL_W = 2;

   typedef struct packed {
      logic              sync_mode;
      logic              dbl_en;
      logic [WSEL_W-1:0] width_sel;
      logic [PSEL_W-1:0] pos_sel;
   } strobe_cfg_t;
endpackage

// File: rtl/pxs_pulse_track.sv
module pxs_pulse_track #(
   parameter int MAX_HI = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pix_timing_i,
   output logic ts_q,
   output logic pix_start,
   output logic err_q
);
   localparam int HC_W = $clog2(MAX_HI + 2);
   localparam logic [HC_W-1:0] HI_LIM = HC_W'(MAX_HI);

   logic [HC_W-1:0] hi_cnt;

   initial begin
      assert (MAX_HI >= 1) else $error("MAX_HI must be at least 1");
   end

   assign pix_start = ts_q & ~pix_timing_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ts_q   <= 1'b0;
         hi_cnt <= '0;
         err_q  <= 1'b0;
      end else begin
         ts_q  <= pix_timing_i;
         err_q <= pix_timing_i && (hi_cnt >= HI_LIM);
         if (!pix_timing_i)
            hi_cnt <= '0;
         else if (hi_cnt <= HI_LIM)
            hi_cnt <= hi_cnt + 1'b1;
      end
   end

   // R8
   err_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> ts_q);
endmodule

// File: rtl/pxs_phase.sv
module pxs_phase #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_start,
   output logic [CNT_W-1:0] phase,
   output logic [CNT_W-1:0] period,
   output logic             started,
   output logic             period_ok
);
   localparam logic [CNT_W-1:0] PH_MAX = '1;

   initial begin
      assert (CNT_W >= 4) else $error("CNT_W must be at least 4");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= '0;
         period    <= '0;
         started   <= 1'b0;
         period_ok <= 1'b0;
      end else if (pix_start) begin
         phase     <= '0;
         period    <= (phase == PH_MAX) ? PH_MAX : phase + 1'b1;
         started   <= 1'b1;
         period_ok <= started;
      end else if (phase != PH_MAX) begin
         phase <= phase + 1'b1;
      end
   end

   // R3
   period_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
      period_ok |-> started);
endmodule

// File: rtl/pxs_strobe_gen.sv
module pxs_strobe_gen
   import pxs_pkg::*;
#(
   parameter int CNT_W     = 6,
   parameter int POS_BASE  = 2,
   parameter bit DIRECT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_timing_i,
   input  logic             pix_start,
   input  logic             started,
   input  logic             period_ok,
   input  logic [CNT_W-1:0] phase,
   input  logic [CNT_W-1:0] period,
   input  strobe_cfg_t      cfg_in,
   output logic             dat_q,
   output logic             dat_fall_q,
   output logic             ref_q,
   output logic             ref_fall_q
);
   localparam int CW1 = CNT_W + 1;

   strobe_cfg_t   cfg_q;
   logic          sync_eff;
   logic [CW1-1:0] w_ext;
   logic          rise_hit, ref_hit;
   logic          sync_d, dat_d, ref_d;

   initial begin
      assert (POS_BASE >= 2) else $error("POS_BASE must be at least 2");
      assert (CNT_W > WSEL_W + 1) else $error("CNT_W too small for width field");
   end

   generate
      if (DIRECT_EN) begin : g_direct
         assign sync_eff = cfg_q.sync_mode;
      end else begin : g_sync_only
         assign sync_eff = 1'b1;
      end
   endgenerate

   assign w_ext    = CW1'(cfg_q.width_sel) + CW1'(1);
   assign rise_hit = period_ok && (({1'b0, phase} + w_ext + CW1'(1)) == {1'b0, period});
   assign ref_hit  = started && cfg_q.dbl_en && !pix_start &&
                     (({1'b0, phase} + CW1'(2)) == (CW1'(cfg_q.pos_sel) + CW1'(POS_BASE)));

   always_comb begin
      if (pix_start)     sync_d = 1'b0;
      else if (rise_hit) sync_d = 1'b1;
      else               sync_d = dat_q;
      dat_d = sync_eff ? sync_d : pix_timing_i;
      ref_d = ref_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q      <= '0;
         dat_q      <= 1'b0;
         dat_fall_q <= 1'b0;
         ref_q      <= 1'b0;
         ref_fall_q <= 1'b0;
      end else begin
         if (pix_start || !period_ok)
            cfg_q <= cfg_in;
         dat_q      <= dat_d;
         dat_fall_q <= dat_q & ~dat_d;
         ref_q      <= ref_d;
         ref_fall_q <= ref_q & ~ref_d;
      end
   end

   // R4
   ref_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ref_q) |=> !ref_q);
   // R6
   ref_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cfg_q.dbl_en) && $past(rst_n)) |-> (!ref_q && !ref_fall_q));
   // R2
   dat_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dat_q) && $past(sync_eff) && $past(rst_n)) |-> $past(pix_start));
   // R7
   direct_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(sync_eff) && $past(rst_n)) |-> (dat_q == $past(pix_timing_i)));
   // R2
   dat_fall_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dat_fall_q |-> (!dat_q && $past(dat_q)));
endmodule

// File: rtl/pixel_sample_strobe_gen.sv
module pixel_sample_strobe_gen
   import pxs_pkg::*;
#(
   parameter int CNT_W     = 6,
   parameter int MAX_HI    = 3,
   parameter int POS_BASE  = 2,
   parameter bit DIRECT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_timing_i,
   input  logic              sync_mode,
   input  logic              dbl_samp_en,
   input  logic [WSEL_W-1:0] data_width_sel,
   input  logic [PSEL_W-1:0] ref_pos_sel,
   output logic              data_strobe_o,
   output logic              data_fall_o,
   output logic              ref_strobe_o,
   output logic              ref_fall_o,
   output logic              clamp_close_o,
   output logic              pulse_err_o
);
   logic             ts_q, pix_start, started, period_ok;
   logic [CNT_W-1:0] phase, period;
   strobe_cfg_t      cfg_in;

   assign cfg_in = '{sync_mode: sync_mode, dbl_en: dbl_samp_en,
                     width_sel: data_width_sel, pos_sel: ref_pos_sel};

   pxs_pulse_track #(.MAX_HI(MAX_HI)) trk_i (
      .clk(clk), .rst_n(rst_n), .pix_timing_i(pix_timing_i),
      .ts_q(ts_q), .pix_start(pix_start), .err_q(pulse_err_o));

   pxs_phase #(.CNT_W(CNT_W)) ph_i (
      .clk(clk), .rst_n(rst_n), .pix_start(pix_start),
      .phase(phase), .period(period), .started(started), .period_ok(period_ok));

   pxs_strobe_gen #(.CNT_W(CNT_W), .POS_BASE(POS_BASE), .DIRECT_EN(DIRECT_EN)) gen_i (
      .clk(clk), .rst_n(rst_n), .pix_timing_i(pix_timing_i), .pix_start(pix_start),
      .started(started), .period_ok(period_ok), .phase(phase), .period(period),
      .cfg_in(cfg_in), .dat_q(data_strobe_o), .dat_fall_q(data_fall_o),
      .ref_q(ref_strobe_o), .ref_fall_q(ref_fall_o));

   assign clamp_close_o = ref_strobe_o;
endmodule

// File: tb/pixel_sample_strobe_gen_tb_top.sv
module pixel_sample_strobe_gen_tb_top;
   localparam int HN = 2048;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pix_t = 1'b0;
   logic sync_mode = 1'b1;
   logic dbl_en = 1'b1;
   logic [1:0] wsel = 2'd0;
   logic [1:0] psel = 2'd0;
   logic dat_o, datf_o, ref_o, reff_o, clamp_o, err_o;

   int total = 0;
   int bad = 0;
   int edge_n = 0;
   bit done = 1'b0;
   logic [HN-1:0] h_dat, h_datf, h_ref, h_reff, h_clamp, h_err, h_ts;
   int fe_list[8];
   int hs_list[8];

   always #4 clk = ~clk;

   pixel_sample_strobe_gen dut_i (
      .clk(clk), .rst_n(rst_n), .pix_timing_i(pix_t), .sync_mode(sync_mode),
      .dbl_samp_en(dbl_en), .data_width_sel(wsel), .ref_pos_sel(psel),
      .data_strobe_o(dat_o), .data_fall_o(datf_o), .ref_strobe_o(ref_o),
      .ref_fall_o(reff_o), .clamp_close_o(clamp_o), .pulse_err_o(err_o));

   always @(posedge clk) begin
      h_ts[(edge_n + 1) % HN] <= pix_t;
      edge_n <= edge_n + 1;
   end

   always @(negedge clk) begin
      h_dat[edge_n % HN]   = dat_o;
      h_datf[edge_n % HN]  = datf_o;
      h_ref[edge_n % HN]   = ref_o;
      h_reff[edge_n % HN]  = reff_o;
      h_clamp[edge_n % HN] = clamp_o;
      h_err[edge_n % HN]   = err_o;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic pixel(input int idx, input int hi, input int per,
                        input int chg_j, input logic [1:0] chg_w);
      for (int j = 0; j < per; j++) begin
         @(negedge clk);
         if (j == 0) hs_list[idx] = edge_n + 1;
         if (j == hi) fe_list[idx] = edge_n + 1;
         pix_t = (j < hi);
         if (j == chg_j) wsel = chg_w;
      end
   endtask

   task automatic settle();
      @(negedge clk);
      #1;
   endtask

   task automatic check_dat(input int fe, input int w, input string tag);
      int ones = 0;
      for (int k = fe - w; k < fe; k++) ones += int'(h_dat[k % HN]);
      chk(ones == w && !h_dat[(fe - w - 1) % HN] && !h_dat[fe % HN],
          {tag, " data strobe width"}, ones, w);
      chk(h_datf[fe % HN] && !h_datf[(fe - 1) % HN] && !h_datf[(fe + 1) % HN],
          "R2 data fall marker", int'(h_datf[fe % HN]), 1);
   endtask

   task automatic check_ref(input int fe, input int d, input bit en);
      chk(h_ref[(fe + d - 1) % HN] == en && !h_ref[(fe + d - 2) % HN] && !h_ref[(fe + d) % HN],
          en ? "R4 reference strobe placement" : "R6 reference strobe off",
          int'(h_ref[(fe + d - 1) % HN]), int'(en));
      chk(h_reff[(fe + d) % HN] == en && !h_reff[(fe + d - 1) % HN],
          "R4 reference fall marker", int'(h_reff[(fe + d) % HN]), int'(en));
      chk(h_clamp[(fe + d - 1) % HN] == en && !h_clamp[(fe + d) % HN],
          "R5 clamp follows reference", int'(h_clamp[(fe + d - 1) % HN]), int'(en));
   endtask

   task automatic sc_reset();
      #1;
      chk({dat_o, datf_o, ref_o, reff_o, clamp_o, err_o} == 6'b0, "R1 outputs in reset",
          int'({dat_o, datf_o, ref_o, reff_o, clamp_o, err_o}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk({dat_o, datf_o, ref_o, reff_o, clamp_o, err_o} == 6'b0, "R1 outputs after reset",
          int'({dat_o, datf_o, ref_o, reff_o, clamp_o, err_o}), 0);
   endtask

   task automatic sc_sync(input int hi, input logic [1:0] w, input logic [1:0] p, input bit en);
      int ones = 0;
      sync_mode = 1'b1; wsel = w; psel = p; dbl_en = en;
      for (int i = 0; i < 4; i++) pixel(i, hi, 10, -1, 2'd0);
      settle();
      for (int i = 2; i < 4; i++) begin
         check_dat(fe_list[i], int'(w) + 1, "R3");
         check_ref(fe_list[i], int'(p) + 2, en);
         chk(!h_err[(fe_list[i] - 1) % HN], "R8 no error for short pulse",
             int'(h_err[(fe_list[i] - 1) % HN]), 0);
      end
      if (!en) begin
         for (int k = hs_list[2]; k < hs_list[3] + 10; k++)
            ones += int'(h_ref[k % HN]) + int'(h_reff[k % HN]) + int'(h_clamp[k % HN]);
         chk(ones == 0, "R6 reference path silent", ones, 0);
      end
   endtask

   task automatic sc_direct();
      int mism = 0;
      int falls = 0;
      sync_mode = 1'b0; dbl_en = 1'b0;
      pixel(0, 2, 10, -1, 2'd0);
      pixel(1, 3, 10, -1, 2'd0);
      pixel(2, 1, 10, -1, 2'd0);
      pixel(3, 2, 10, -1, 2'd0);
      settle();
      for (int k = fe_list[1] + 1; k < hs_list[3] + 10; k++) begin
         if (h_dat[k % HN] != h_ts[k % HN]) mism++;
         if (h_datf[k % HN] != (h_ts[(k - 1) % HN] & ~h_ts[k % HN])) mism++;
         falls += int'(h_datf[k % HN]);
      end
      chk(mism == 0, "R7 direct pass-through", mism, 0);
      chk(falls == 2, "R7 direct fall markers", falls, 2);
   endtask

   task automatic sc_err();
      int s;
      sync_mode = 1'b1; dbl_en = 1'b1;
      pixel(0, 4, 10, -1, 2'd0);
      settle();
      s = hs_list[0];
      chk(!h_err[(s + 2) % HN], "R8 no error on third high edge", int'(h_err[(s + 2) % HN]), 0);
      chk(h_err[(s + 3) % HN], "R8 error on fourth high edge", int'(h_err[(s + 3) % HN]), 1);
      chk(!h_err[(s + 4) % HN], "R8 error clears on low sample", int'(h_err[(s + 4) % HN]), 0);
   endtask

   task automatic sc_cfg();
      sync_mode = 1'b1; dbl_en = 1'b1; wsel = 2'd0; psel = 2'd1;
      for (int i = 0; i < 3; i++) pixel(i, 2, 10, -1, 2'd0);
      pixel(3, 2, 10, 3, 2'd3);
      pixel(4, 2, 10, -1, 2'd0);
      pixel(5, 2, 10, -1, 2'd0);
      settle();
      check_dat(fe_list[4], 1, "R9 old width kept");
      check_dat(fe_list[5], 4, "R9 new width applied");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", edge_n, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      sc_reset();
      sc_sync(1, 2'd0, 2'd0, 1'b1);
      sc_sync(3, 2'd3, 2'd3, 1'b1);
      sc_sync(2, 2'd1, 2'd2, 1'b0);
      sc_sync(3, 2'd2, 2'd1, 1'b1);
      sc_direct();
      sc_err();
      sc_cfg();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule